// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a cycle-accurate, synthesizable model of a synchronous SRAM with a registered address, a flow-through read path and a four-beat burst counter. An address strobe captures the address on a rising clock edge. From the cycle that follows, the addressed word is driven straight from the array with no output register. While the advance input is held low, the next three beats walk the other words of the same aligned four-word block. They walk the block either in linear order or in exclusive-or (interleaved) order.

Writes are decided per byte lane. A global write stores every lane. Otherwise the lanes whose select is low are stored, and only when the lane-write enable is low. Chip enable and two chip selects are sampled on strobe cycles, and deselection takes effect in the next cycle. The output enable and the sleep input gate the output directly. While sleep is high, writes are blocked and the burst state is frozen. The data-in and data-out buses are split instead of sharing a bidirectional pin.

Top module: `sburst_sram`

## Requirements
- R1: After an edge with an accepted address strobe and a selected chip, `dout` carries the word stored at the loaded address during the very next cycle, with `dout_en` high while `oe_n` is low.
- R2: With `lbo` low (linear order), beat k of a burst starting at low address bits s reads the word at low bits (s+k) mod 4. Each edge with `adv_n` low and no strobe moves to the next beat.
- R3: With `lbo` high (interleaved order), beat k of a burst reads the word at low bits s XOR k.
- R4: The burst never changes address bits above bit 1. A fifth beat (the fourth advance) returns to the first beat's address.
- R5: A low `adsp_n` is ignored while `ce_n` is high. When no strobe is accepted and `adv_n` is high, the current address and output stay unchanged.
- R6: On a cycle started by `adsc_n`, the write controls sampled together with the address decide the write to the first beat. The data comes from the next edge, and the write controls present at that next edge are ignored.
- R7: On a cycle started by `adsp_n`, the write controls on the strobe edge are ignored. The write to the first beat is decided by the controls at the following edge.
- R8: With `gw_n` low, all four byte lanes are written, whatever `bwe_n` and `bw_n` are.
- R9: With `gw_n` high and `bwe_n` low, lane i (`din[9i+8:9i]`) is written only when `bw_n[i]` is low. With `bwe_n` high, no lane is written even if `bw_n` is low.
- R10: A strobe edge with `ce_n` high, `cs0` low or `cs1_n` high deselects the device. From the next cycle `dout_en` is low, and writes are blocked until a selected strobe.
- R11: `dout_en` is low in any cycle in which `oe_n` is high, and `dout` reads zero whenever `dout_en` is low.
- R12: While `zz` is high, `dout_en` is low, no write takes place, and the burst address and count are held. After `zz` falls, the burst resumes from the held beat.
- R13: A low `rst_n` at a clock edge leaves the device deselected, so `dout_en` stays low until a selected strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW (6) | Word address |
| adsp_n | input | 1 | Processor-side address strobe, active low, gated by `ce_n` |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lbo | input | 1 | Burst order: 0 linear, 1 interleaved |
| ce_n | input | 1 | Chip enable, active low |
| cs0 | input | 1 | Chip select, active high |
| cs1_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Lane-write enable, active low |
| bw_n | input | LANES (4) | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| zz | input | 1 | Sleep, active high, asynchronous to the output |
| din | input | LANES*LANE_W (36) | Write data |
| dout | output | LANES*LANE_W (36) | Flow-through read data, zero when disabled |
| dout_en | output | 1 | Read data valid and driven |

## Verification
The assertions take `lbo` as constant within a burst. The linear-step property compares consecutive beats under one order, so a change of `lbo` in mid-burst would break that comparison. They also take `zz` and strobes as sampled levels at the clock, not glitches between edges. The stimulus changes `lbo` only on a strobe cycle. It drives every input at the falling edge and samples `dout` three nanoseconds after the rising edge, so each sample sees settled values from one cycle.

// File: rtl/sburst_pkg.sv
`timescale 1ns/1ps
package sburst_pkg;

  // Low two address bits of a burst beat: XOR walk or modulo-4 count.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       interleave);
    logic [1:0] r;
    if (interleave) r = start ^ step;
    else            r = start + step;
    return r;
  endfunction

  // Lane mask selected by the write controls of one edge.
  function automatic logic [3:0] lane_mask4(input logic gw_n,
                                            input logic bwe_n,
                                            input logic [3:0] bw_n);
    logic [3:0] m;
    if (!gw_n)       m = 4'hF;
    else if (!bwe_n) m = ~bw_n;
    else             m = 4'h0;
    return m;
  endfunction

endpackage

// File: rtl/sburst_ctrl.sv
`timescale 1ns/1ps
module sburst_ctrl
  import sburst_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zz,
  input  logic [AW-1:0]    addr,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             lbo,
  input  logic             ce_n,
  input  logic             cs0,
  input  logic             cs1_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [AW-1:0]    cur_addr,
  output logic             active,
  output logic             sel,
  output logic [LANES-1:0] wr_lanes,
  output logic             load_evt,
  output logic             adv_evt,
  output logic             wr_evt
);

  localparam int UW = AW - 2;

  logic [AW-1:0]    base_q;
  logic [1:0]       step_q;
  logic             act_q;
  logic             from_c_q;
  logic [LANES-1:0] pend_q;

  logic             take_p;
  logic             take_c;
  logic             strobe;
  logic [LANES-1:0] live_mask;
  logic [LANES-1:0] eff_mask;

  always_comb begin
    take_p = !adsp_n && !ce_n;
    take_c = !adsc_n && !take_p;
    strobe = take_p || take_c;
    if (!gw_n)       live_mask = '1;
    else if (!bwe_n) live_mask = ~bw_n;
    else             live_mask = '0;
    eff_mask = from_c_q ? pend_q : live_mask;
  end

  assign sel      = !ce_n && cs0 && !cs1_n;
  assign load_evt = strobe && !zz;
  assign adv_evt  = !zz && !strobe && !adv_n && act_q;
  assign wr_lanes = (act_q && !zz && !strobe) ? eff_mask : '0;
  assign wr_evt   = |wr_lanes;
  assign active   = act_q;
  assign cur_addr = {base_q[AW-1 -: UW], burst_low(base_q[1:0], step_q, lbo)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      step_q   <= '0;
      act_q    <= 1'b0;
      from_c_q <= 1'b0;
      pend_q   <= '0;
    end else if (!zz) begin
      if (strobe) begin
        base_q   <= addr;
        step_q   <= '0;
        act_q    <= sel;
        from_c_q <= take_c;
        pend_q   <= live_mask;
      end else begin
        from_c_q <= 1'b0;
        if (!adv_n && act_q) step_q <= step_q + 2'd1;
      end
    end
  end

endmodule

// File: rtl/sburst_array.sv
`timescale 1ns/1ps
module sburst_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [AW-1:0]           raddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/sburst_sram.sv
`timescale 1ns/1ps
module sburst_sram #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    lbo,
  input  logic                    ce_n,
  input  logic                    cs0,
  input  logic                    cs1_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic                    zz,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int DW = LANES * LANE_W;

  logic [AW-1:0]    cur_addr;
  logic             active;
  logic             sel;
  logic [LANES-1:0] wr_lanes;
  logic             load_evt;
  logic             adv_evt;
  logic             wr_evt;
  logic [DW-1:0]    rdata;

  sburst_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .zz       (zz),
    .addr     (addr),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .adv_n    (adv_n),
    .lbo      (lbo),
    .ce_n     (ce_n),
    .cs0      (cs0),
    .cs1_n    (cs1_n),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bw_n     (bw_n),
    .cur_addr (cur_addr),
    .active   (active),
    .sel      (sel),
    .wr_lanes (wr_lanes),
    .load_evt (load_evt),
    .adv_evt  (adv_evt),
    .wr_evt   (wr_evt)
  );

  sburst_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (wr_lanes),
    .waddr (cur_addr),
    .raddr (cur_addr),
    .wdata (din),
    .rdata (rdata)
  );

  assign dout_en = active && !oe_n && !zz;
  assign dout    = dout_en ? rdata : '0;

endmodule

// File: rtl/sburst_sram_chk.sv
`timescale 1ns/1ps
module sburst_sram_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          zz,
  input logic          oe_n,
  input logic          lbo,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] cur_addr,
  input logic          active,
  input logic          sel,
  input logic          load_evt,
  input logic          adv_evt,
  input logic          wr_evt,
  input logic          dout_en
);

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cur_addr == $past(addr)); // R1
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !lbo) |=> cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1); // R2
  AST_BLOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])); // R4
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !sel) |=> !active && !dout_en && !wr_evt); // R10
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en); // R11
  AST_ZZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    zz |-> !dout_en && !wr_evt); // R12
  AST_ZZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> $stable(cur_addr) && $stable(active)); // R12

endmodule

bind sburst_sram sburst_sram_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .zz       (zz),
  .oe_n     (oe_n),
  .lbo      (lbo),
  .addr     (addr),
  .cur_addr (cur_addr),
  .active   (active),
  .sel      (sel),
  .load_evt (load_evt),
  .adv_evt  (adv_evt),
  .wr_evt   (wr_evt),
  .dout_en  (dout_en)
);

// File: tb/sburst_sram_tb.sv
`timescale 1ns/1ps
module sburst_sram_tb;

  localparam int AW = 6;
  localparam int LANES = 4;
  localparam int LW = 9;
  localparam int DW = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic adsp_n, adsc_n, adv_n, lbo, ce_n, cs0, cs1_n;
  logic gw_n, bwe_n, oe_n, zz;
  logic [LANES-1:0] bw_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic dout_en;

  always #4 clk = ~clk;

  sburst_sram #(.AW(AW), .LANES(LANES), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .lbo(lbo), .ce_n(ce_n), .cs0(cs0), .cs1_n(cs1_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .zz(zz),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] exp_d [$];
  logic          exp_en [$];
  string         exp_tag [$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // Address of beat k: linear counts modulo 4, interleaved flips bits.
  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int k, input bit il);
    int lo;
    if (il) lo = int'(a[1:0]) ^ (k % 4);
    else    lo = (int'(a[1:0]) + k) % 4;
    return {a[AW-1:2], 2'(lo)};
  endfunction

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input int k, input int seed);
    logic [DW-1:0] v;
    v = DW'(seed * 7919 + int'(a) * 131 + k * 17);
    return (v * 36'd40503) ^ 36'h9C3A5E1B7;
  endfunction

  task automatic expect_now(input logic [DW-1:0] d, input logic en, input string tag);
    @(posedge clk);
    exp_d.push_back(en ? d : '0);
    exp_en.push_back(en);
    exp_tag.push_back(tag);
  endtask

  task automatic go_idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; ce_n = 0; cs0 = 1; cs1_n = 0;
    gw_n = 1; bwe_n = 1; bw_n = '1; oe_n = 1; zz = 0;
  endtask

  // Write controls for one edge; g selects global write with lane controls off.
  task automatic drive_ctrl(input logic [3:0] m, input bit g);
    if (g) begin gw_n = 0; bwe_n = 1; bw_n = 4'hF; end
    else if (m == 4'h0) begin gw_n = 1; bwe_n = 1; bw_n = 4'h0; end
    else begin gw_n = 1; bwe_n = 0; bw_n = ~m; end
  endtask

  task automatic shadow_write(input logic [AW-1:0] a, input logic [3:0] m, input logic [DW-1:0] d);
    for (int i = 0; i < LANES; i++)
      if (m[i]) shadow[a][i*LW +: LW] = d[i*LW +: LW];
  endtask

  task automatic wr_burst(input logic [AW-1:0] a, input bit use_c, input bit il,
                          input logic [3:0] m0, input logic [3:0] m1,
                          input logic [3:0] m2, input logic [3:0] m3,
                          input bit g0, input int seed);
    logic [3:0] ms [4];
    ms[0] = m0; ms[1] = m1; ms[2] = m2; ms[3] = m3;
    @(negedge clk);
    go_idle();
    addr = a; lbo = il;
    if (use_c) begin adsc_n = 0; drive_ctrl(m0, g0); end
    else begin adsp_n = 0; gw_n = 0; end       // R7: ignored on the strobe edge
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      adsc_n = 1; adsp_n = 1; adv_n = 0;
      din = pat(a, k, seed);
      if (use_c && k == 0) begin gw_n = 1; bwe_n = 0; bw_n = 4'h0; end  // R6: ignored
      else drive_ctrl(ms[k], (k == 0) && g0);
      shadow_write(beat_addr(a, k, il), (k == 0 && g0) ? 4'hF : ms[k], din);
    end
    @(negedge clk);
    go_idle();
  endtask

  task automatic rd_burst(input logic [AW-1:0] a, input bit use_c, input bit il, input string tag);
    @(negedge clk);
    go_idle();
    addr = a; lbo = il; oe_n = 0;
    if (use_c) adsc_n = 0; else adsp_n = 0;
    expect_now(shadow[beat_addr(a, 0, il)], 1'b1, tag);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      adsc_n = 1; adsp_n = 1; adv_n = 0;
      expect_now(shadow[beat_addr(a, k, il)], 1'b1, (k == 4) ? "R4" : tag);
    end
    @(negedge clk);
    go_idle();
  endtask

  // Monitor: compares every queued item 3 ns after the edge it belongs to.
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (exp_d.size() > 0) begin
        logic [DW-1:0] d;
        logic en;
        string t;
        d = exp_d.pop_front();
        en = exp_en.pop_front();
        t = exp_tag.pop_front();
        n_vec++;
        if (dout_en !== en || dout !== d) begin
          n_bad++;
          $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h", t, dout_en, dout, en, d);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    go_idle();
    addr = '0; lbo = 0; din = '0; rst_n = 0;
    oe_n = 0;
    repeat (3) @(negedge clk);
    expect_now('0, 1'b0, "R13");            // in reset
    @(negedge clk);
    rst_n = 1; oe_n = 0;
    expect_now('0, 1'b0, "R13");            // after release, still deselected

    // Prefill all blocks, global write on the first beat (R8)
    for (int b = 0; b < DEPTH / 4; b++)
      wr_burst(AW'(b * 4), 1'b1, 1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 1'b1, b);

    // Linear and interleaved bursts from every start (R1, R2, R3, R4)
    for (int s = 0; s < 4; s++) rd_burst(AW'(8 + s), 1'b1, 1'b0, "R2");
    for (int s = 0; s < 4; s++) rd_burst(AW'(20 + s), 1'b0, 1'b1, "R3");
    rd_burst(AW'(33), 1'b0, 1'b0, "R1");

    // All 16 lane masks, both strobes and both orders (R6, R7, R9)
    for (int m = 0; m < 16; m++) begin
      wr_burst(AW'(m * 4 + (m % 4)), m[0], m[1], 4'(m), 4'(~m), 4'({m[1:0], m[3:2]}),
               4'h0, 1'b0, 100 + m);
      rd_burst(AW'(m * 4), 1'b1, 1'b0, m[0] ? "R6" : "R7");
    end

    // Deselect via chip select and via chip enable on an ADSC strobe (R10)
    for (int v = 0; v < 2; v++) begin
      @(negedge clk);
      go_idle();
      addr = AW'(12); oe_n = 0; adsc_n = 0;
      if (v == 0) cs0 = 0; else ce_n = 1;
      expect_now('0, 1'b0, "R10");
      @(negedge clk);
      adsc_n = 1; cs0 = 1; ce_n = 0; adv_n = 0; gw_n = 0; din = '1;
      expect_now('0, 1'b0, "R10");
      @(negedge clk);
      go_idle();
      rd_burst(AW'(12), 1'b1, 1'b0, "R10");
    end

    // ADSP ignored while chip enable is high (R5)
    @(negedge clk);
    go_idle();
    addr = AW'(40); oe_n = 0; adsc_n = 0;
    expect_now(shadow[40], 1'b1, "R1");
    @(negedge clk);
    adsc_n = 1; adsp_n = 0; ce_n = 1; addr = AW'(57);
    expect_now(shadow[40], 1'b1, "R5");
    @(negedge clk);
    adsp_n = 1; ce_n = 0; adv_n = 0;
    expect_now(shadow[41], 1'b1, "R5");

    // Output enable gating (R11)
    @(negedge clk);
    adv_n = 1; oe_n = 1;
    expect_now('0, 1'b0, "R11");
    @(negedge clk);
    oe_n = 0;
    expect_now(shadow[41], 1'b1, "R11");

    // Sleep: output off, write blocked, beat held (R12)
    @(negedge clk);
    go_idle();
    addr = AW'(46); oe_n = 0; lbo = 0; adsc_n = 0;
    expect_now(shadow[46], 1'b1, "R1");
    @(negedge clk);
    adsc_n = 1; zz = 1; adv_n = 0; gw_n = 0; din = '0;
    expect_now('0, 1'b0, "R12");
    @(negedge clk);
    expect_now('0, 1'b0, "R12");
    @(negedge clk);
    zz = 0; gw_n = 1; adv_n = 0;
    expect_now(shadow[47], 1'b1, "R12");
    @(negedge clk);
    go_idle();
    rd_burst(AW'(46), 1'b1, 1'b0, "R12");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule